// File: doc/BRIEF.md
# Bank-Mode Channel and Stream Allocator

This block shares the processing resources of a 32-channel converter array among acquisition tasks. A task asks for a set of channels, given as a bitmask, and for one of two modes: buffered or low-latency single-point. The allocator gives each accepted task one timing engine, enough filter streams of its mode to cover its channels, and a crosspoint map that tells each channel which stream serves it. A later release that names the task identifier returns all of these at once.

The channels sit in four banks of eight. Each bank can run in only one mode at a time. Because of this, two tasks can clash even when they ask for different channels. A bank takes the mode of the first running task that holds a channel in it, and it keeps that mode until the last such task is released. Each request gets exactly one response, either a grant or an error code, after a fixed number of cycles.

Top module: `bank_stream_alloc`

## Requirements
- R1: A request is rejected with error code 1 when any of its channels lies in a bank where a running task of the other mode holds a channel. Banks are channels 0-7, 8-15, 16-23 and 24-31. Mode 0 is buffered and mode 1 is single-point.
- R2: A bank's mode lock clears as soon as no running task holds a channel in it. After that, a request in either mode may use the bank.
- R3: A request that names a channel already held by a running task is rejected with error code 2, even when both tasks use the same mode.
- R4: No more than four tasks run at once. A request made while four are running is rejected with error code 3, whatever channels or mode it asks for.
- R5: A granted task receives ceil(channel count / 8) streams from the four-stream pool of its own mode, taken from the lowest free indices, as a 4-bit mask on `rsp_streams`. When the pool has too few free streams, the request is rejected with error code 4.
- R6: The crosspoint map gives each channel c a 2-bit stream index at bits [2c+1:2c]. Taking the requested channels in ascending order, the k-th channel (counting from 0) is served by the (floor(k/8))-th lowest of the granted streams. Fields for channels outside the request are 0.
- R7: A granted task receives the lowest-numbered free timing engine, reported on `rsp_eng`.
- R8: The block accepts a request on a rising edge where both `req_valid` and `req_ready` are high. `rsp_valid` is high for exactly the one cycle after the following rising edge. `req_ready` is low between the acceptance and the response.
- R9: A release (op 1) with the identifier of a running task frees its engine, streams and channels. It succeeds and reports the freed engine and stream mask. A release with an unknown identifier gets error code 6.
- R10: An allocation (op 0) with an empty mask, or with an identifier already held by a running task, gets error code 5. When several errors apply, the one reported is the first in this order: 5, 3, 1, 2, 4.
- R11: After reset, `req_ready` is 1, `rsp_valid` is 0 and no task holds any resource.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 allocate, 1 release |
| req_tid | input | 4 | Task identifier |
| req_mask | input | 32 | Requested channels |
| req_mode | input | 1 | 0 buffered, 1 single-point |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Request granted or release done |
| rsp_err | output | 3 | Error code, 0 on success |
| rsp_tid | output | 4 | Identifier of the answered request |
| rsp_eng | output | 2 | Engine index |
| rsp_streams | output | 4 | Stream mask within the task's mode pool |
| rsp_map | output | 64 | Crosspoint stream index per channel |

## Verification
Every result of this block appears in one place: the single response cycle that comes two rising edges after the acceptance edge. The engine state that a response implies shows up only through the responses to later requests. For each request, the bench task drives on a falling edge and waits for acceptance. It then samples on the next falling edge, where `rsp_valid` and `req_ready` must both be low, and again on the one after, where the response must be present. All fields are captured at that second falling edge, away from the clock edge. Whether a release freed its resources is judged only from the responses to later requests.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_MODE   = 3'd1,
        ERR_BUSY   = 3'd2,
        ERR_NOENG  = 3'd3,
        ERR_NOSTR  = 3'd4,
        ERR_BADREQ = 3'd5,
        ERR_NOTASK = 3'd6
    } err_e;

    localparam logic MODE_BUF = 1'b0;
    localparam logic MODE_SP  = 1'b1;
    localparam logic OP_ALLOC = 1'b0;
    localparam logic OP_REL   = 1'b1;
endpackage

// File: rtl/bank_lock_view.sv
module bank_lock_view #(
    parameter int NUM_CH  = 32,
    parameter int BANK_SZ = 8,
    parameter int NUM_ENG = 4,
    localparam int NUM_BANK = NUM_CH / BANK_SZ
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_ENG-1:0]               eng_busy,
    input  logic [NUM_ENG-1:0]               eng_mode,
    input  logic [NUM_ENG-1:0][NUM_CH-1:0]   eng_mask,
    output logic [NUM_BANK-1:0]              bank_used,
    output logic [NUM_BANK-1:0]              bank_mode,
    output logic [NUM_CH-1:0]                ch_owned
);
    logic [NUM_CH-1:0][NUM_ENG-1:0] owner;
    logic [NUM_ENG-1:0][NUM_BANK-1:0] touch;

    always_comb begin
        ch_owned  = '0;
        bank_used = '0;
        bank_mode = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            for (int b = 0; b < NUM_BANK; b++) begin
                touch[e][b] = eng_busy[e] && (|eng_mask[e][b*BANK_SZ +: BANK_SZ]);
                if (touch[e][b]) begin
                    bank_used[b] = 1'b1;
                    bank_mode[b] = eng_mode[e];
                end
            end
            if (eng_busy[e]) ch_owned = ch_owned | eng_mask[e];
        end
        for (int c = 0; c < NUM_CH; c++)
            for (int e = 0; e < NUM_ENG; e++)
                owner[c][e] = eng_busy[e] && eng_mask[e][c];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chx
        AST_CHAN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owner[c])); // R3
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        for (genvar e1 = 0; e1 < NUM_ENG; e1++) begin : g_e1
            for (genvar e2 = e1 + 1; e2 < NUM_ENG; e2++) begin : g_e2
                AST_BANK_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
                    (touch[e1][b] && touch[e2][b]) |-> (eng_mode[e1] == eng_mode[e2])); // R1
            end
        end
    end
endmodule

// File: rtl/stream_picker.sv
module stream_picker #(
    parameter int NUM_CH  = 32,
    parameter int NUM_STR = 4,
    parameter int STR_CAP = 8,
    localparam int STR_W = (NUM_STR > 1) ? $clog2(NUM_STR) : 1,
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input  logic [NUM_STR-1:0]            free_str,
    input  logic [NUM_CH-1:0]             ch_mask,
    output logic [NUM_STR-1:0]            pick,
    output logic                          enough,
    output logic [NUM_CH*STR_W-1:0]       xmap
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] need;
    logic [NUM_STR-1:0][STR_W-1:0] slot;
    int unsigned taken;
    int unsigned rank;

    always_comb begin
        cnt   = CNT_W'($countones(ch_mask));
        need  = CNT_W'((int'(cnt) + STR_CAP - 1) / STR_CAP);
        pick  = '0;
        slot  = '0;
        taken = 0;
        for (int s = 0; s < NUM_STR; s++) begin
            if (free_str[s] && (taken < int'(need))) begin
                pick[s] = 1'b1;
                slot[taken[STR_W-1:0]] = STR_W'(s);
                taken = taken + 1;
            end
        end
        enough = (taken == int'(need));
        xmap = '0;
        rank = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_mask[c]) begin
                if ((rank / STR_CAP) < NUM_STR)
                    xmap[c*STR_W +: STR_W] = slot[(rank / STR_CAP)];
                rank = rank + 1;
            end
        end
    end
endmodule

// File: rtl/bank_stream_alloc.sv
module bank_stream_alloc
    import alloc_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int BANK_SZ = 8,
    parameter int NUM_ENG = 4,
    parameter int NUM_STR = 4,
    parameter int STR_CAP = 8,
    parameter int TID_W   = 4,
    localparam int NUM_BANK = NUM_CH / BANK_SZ,
    localparam int ENG_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
    localparam int STR_W = (NUM_STR > 1) ? $clog2(NUM_STR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_op,
    input  logic [TID_W-1:0]          req_tid,
    input  logic [NUM_CH-1:0]         req_mask,
    input  logic                      req_mode,
    output logic                      rsp_valid,
    output logic                      rsp_ok,
    output logic [2:0]                rsp_err,
    output logic [TID_W-1:0]          rsp_tid,
    output logic [ENG_W-1:0]          rsp_eng,
    output logic [NUM_STR-1:0]        rsp_streams,
    output logic [NUM_CH*STR_W-1:0]   rsp_map
);
    typedef struct packed {
        logic                             stg_vld;
        logic                             stg_op;
        logic [TID_W-1:0]                 stg_tid;
        logic [NUM_CH-1:0]                stg_mask;
        logic                             stg_mode;
        logic [NUM_ENG-1:0]               busy;
        logic [NUM_ENG-1:0]               mode;
        logic [NUM_ENG-1:0][TID_W-1:0]    tid;
        logic [NUM_ENG-1:0][NUM_CH-1:0]   mask;
        logic [NUM_ENG-1:0][NUM_STR-1:0]  strm;
        logic                             r_vld;
        logic                             r_ok;
        err_e                             r_err;
        logic [TID_W-1:0]                 r_tid;
        logic [ENG_W-1:0]                 r_eng;
        logic [NUM_STR-1:0]               r_strm;
        logic [NUM_CH*STR_W-1:0]          r_map;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_BANK-1:0]         bank_used, bank_mode;
    logic [NUM_CH-1:0]           ch_owned;
    logic [NUM_STR-1:0]          free_str, pick;
    logic                        enough;
    logic [NUM_CH*STR_W-1:0]     xmap;
    logic                        tid_hit, eng_free, mode_clash, ch_clash;
    logic [ENG_W-1:0]            hit_idx, free_idx;
    logic [1:0][NUM_STR-1:0][NUM_ENG-1:0] sown;

    bank_lock_view #(.NUM_CH(NUM_CH), .BANK_SZ(BANK_SZ), .NUM_ENG(NUM_ENG)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_busy  (st_q.busy),
        .eng_mode  (st_q.mode),
        .eng_mask  (st_q.mask),
        .bank_used (bank_used),
        .bank_mode (bank_mode),
        .ch_owned  (ch_owned)
    );

    stream_picker #(.NUM_CH(NUM_CH), .NUM_STR(NUM_STR), .STR_CAP(STR_CAP)) u_pick (
        .free_str (free_str),
        .ch_mask  (st_q.stg_mask),
        .pick     (pick),
        .enough   (enough),
        .xmap     (xmap)
    );

    // resource lookups for the staged request
    always_comb begin
        tid_hit  = 1'b0;
        hit_idx  = '0;
        eng_free = 1'b0;
        free_idx = '0;
        free_str = '1;
        for (int e = NUM_ENG - 1; e >= 0; e--) begin
            if (!st_q.busy[e]) begin
                eng_free = 1'b1;
                free_idx = ENG_W'(e);
            end
        end
        for (int e = 0; e < NUM_ENG; e++) begin
            if (st_q.busy[e] && st_q.tid[e] == st_q.stg_tid) begin
                tid_hit = 1'b1;
                hit_idx = ENG_W'(e);
            end
            if (st_q.busy[e] && st_q.mode[e] == st_q.stg_mode)
                free_str = free_str & ~st_q.strm[e];
        end
        mode_clash = 1'b0;
        for (int b = 0; b < NUM_BANK; b++)
            if ((|st_q.stg_mask[b*BANK_SZ +: BANK_SZ]) && bank_used[b] &&
                (bank_mode[b] != st_q.stg_mode))
                mode_clash = 1'b1;
        ch_clash = |(st_q.stg_mask & ch_owned);
    end

    always_comb begin
        st_d = st_q;
        st_d.r_vld = 1'b0;
        if (req_valid && !st_q.stg_vld) begin
            st_d.stg_vld  = 1'b1;
            st_d.stg_op   = req_op;
            st_d.stg_tid  = req_tid;
            st_d.stg_mask = req_mask;
            st_d.stg_mode = req_mode;
        end
        if (st_q.stg_vld) begin
            st_d.stg_vld = 1'b0;
            st_d.r_vld   = 1'b1;
            st_d.r_tid   = st_q.stg_tid;
            st_d.r_ok    = 1'b0;
            st_d.r_eng   = '0;
            st_d.r_strm  = '0;
            st_d.r_map   = '0;
            if (st_q.stg_op == OP_REL) begin
                if (tid_hit) begin
                    st_d.r_ok          = 1'b1;
                    st_d.r_err         = ERR_NONE;
                    st_d.r_eng         = hit_idx;
                    st_d.r_strm        = st_q.strm[hit_idx];
                    st_d.busy[hit_idx] = 1'b0;
                    st_d.mask[hit_idx] = '0;
                    st_d.strm[hit_idx] = '0;
                end else begin
                    st_d.r_err = ERR_NOTASK;
                end
            end else if (st_q.stg_mask == '0 || tid_hit) begin
                st_d.r_err = ERR_BADREQ;
            end else if (!eng_free) begin
                st_d.r_err = ERR_NOENG;
            end else if (mode_clash) begin
                st_d.r_err = ERR_MODE;
            end else if (ch_clash) begin
                st_d.r_err = ERR_BUSY;
            end else if (!enough) begin
                st_d.r_err = ERR_NOSTR;
            end else begin
                st_d.r_ok           = 1'b1;
                st_d.r_err          = ERR_NONE;
                st_d.r_eng          = free_idx;
                st_d.r_strm         = pick;
                st_d.r_map          = xmap;
                st_d.busy[free_idx] = 1'b1;
                st_d.mode[free_idx] = st_q.stg_mode;
                st_d.tid[free_idx]  = st_q.stg_tid;
                st_d.mask[free_idx] = st_q.stg_mask;
                st_d.strm[free_idx] = pick;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.r_err <= ERR_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready   = !st_q.stg_vld;
    assign rsp_valid   = st_q.r_vld;
    assign rsp_ok      = st_q.r_ok;
    assign rsp_err     = st_q.r_err;
    assign rsp_tid     = st_q.r_tid;
    assign rsp_eng     = st_q.r_eng;
    assign rsp_streams = st_q.r_strm;
    assign rsp_map     = st_q.r_map;

    always_comb begin
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < NUM_STR; s++)
                for (int e = 0; e < NUM_ENG; e++)
                    sown[m][s][e] = st_q.busy[e] && (st_q.mode[e] == m[0]) && st_q.strm[e][s];
    end

    for (genvar m = 0; m < 2; m++) begin : g_pool
        for (genvar s = 0; s < NUM_STR; s++) begin : g_str
            AST_STREAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(sown[m][s])); // R5
        end
    end

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!rsp_valid && !req_ready) ##1 rsp_valid); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
    AST_OK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok == (rsp_err == 3'd0))); // R10
    AST_GRANT_HAS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (rsp_streams != '0)); // R5
endmodule

// File: tb/bank_stream_alloc_tb.sv
module bank_stream_alloc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [3:0]  req_tid = '0;
    logic [31:0] req_mask = '0;
    logic        req_mode = 1'b0;
    logic        rsp_valid, rsp_ok;
    logic [2:0]  rsp_err;
    logic [3:0]  rsp_tid;
    logic [1:0]  rsp_eng;
    logic [3:0]  rsp_streams;
    logic [63:0] rsp_map;

    int n_run = 0;
    int n_fail = 0;
    logic        g_ok;
    logic [2:0]  g_err;
    logic [1:0]  g_eng;
    logic [3:0]  g_str;
    logic [63:0] g_map;

    always #10 clk = ~clk;

    bank_stream_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_tid(req_tid), .req_mask(req_mask), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_tid(rsp_tid),
        .rsp_eng(rsp_eng), .rsp_streams(rsp_streams), .rsp_map(rsp_map)
    );

    task automatic chk(input logic cond, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic op, input logic [3:0] tid, input logic [31:0] mask,
                        input logic mode);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_tid = tid; req_mask = mask; req_mode = mode;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!rsp_valid && !req_ready, "R8 gap cycle", {62'd0, rsp_valid, req_ready}, 64'd0);
        @(negedge clk);
        chk(rsp_valid && rsp_tid == tid, "R8 response due", {59'd0, rsp_valid, rsp_tid}, {59'd1, tid});
        g_ok = rsp_ok; g_err = rsp_err; g_eng = rsp_eng; g_str = rsp_streams; g_map = rsp_map;
    endtask

    task automatic expect_err(input string req, input logic [2:0] code);
        chk(!g_ok && g_err == code, req, {61'd0, g_err}, {61'd0, code});
    endtask

    task automatic expect_grant(input string req, input logic [1:0] eng, input logic [3:0] str,
                                input logic [63:0] map);
        chk(g_ok && g_err == 3'd0, req, {61'd0, g_err}, 64'd0);
        chk(g_eng == eng, {req, " engine"}, {62'd0, g_eng}, {62'd0, eng});
        chk(g_str == str, {req, " streams"}, {60'd0, g_str}, {60'd0, str});
        chk(g_map == map, {req, " map"}, g_map, map);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R11 reset state", {62'd0, req_ready, rsp_valid}, 64'd2);
    endtask

    task automatic t_bank_modes;
        xfer(1'b0, 4'd1, 32'h01FF_FFFF, 1'b0);
        expect_grant("R5 R6 25-channel buffered", 2'd0, 4'hF, 64'h0003_AAAA_5555_0000);
        xfer(1'b0, 4'd2, 32'h4000_0000, 1'b0);
        expect_err("R5 pool exhausted", 3'd4);
        xfer(1'b0, 4'd2, 32'h8000_0000, 1'b1);
        expect_err("R1 bank locked to other mode", 3'd1);
        xfer(1'b0, 4'd2, 32'h0000_0020, 1'b0);
        expect_err("R3 channel held same mode", 3'd2);
        xfer(1'b0, 4'd1, 32'h4000_0000, 1'b0);
        expect_err("R10 identifier in use", 3'd5);
        xfer(1'b0, 4'd2, 32'h0, 1'b0);
        expect_err("R10 empty mask", 3'd5);
        xfer(1'b1, 4'd1, 32'h0, 1'b0);
        chk(g_ok && g_eng == 2'd0 && g_str == 4'hF, "R9 release reports",
            {58'd0, g_ok, g_eng, g_str}, {58'd0, 1'b1, 2'd0, 4'hF});
        xfer(1'b1, 4'd1, 32'h0, 1'b0);
        expect_err("R9 unknown release", 3'd6);
        xfer(1'b0, 4'd2, 32'h8000_0000, 1'b1);
        expect_grant("R2 lock cleared", 2'd0, 4'h1, 64'h0);
        xfer(1'b1, 4'd2, 32'h0, 1'b0);
    endtask

    task automatic t_engines;
        xfer(1'b0, 4'd3, 32'h0000_0001, 1'b0);
        expect_grant("R7 first engine", 2'd0, 4'h1, 64'h0);
        xfer(1'b0, 4'd4, 32'h0000_0100, 1'b0);
        expect_grant("R7 second engine", 2'd1, 4'h2, 64'h0000_0000_0001_0000);
        xfer(1'b0, 4'd5, 32'h0001_0000, 1'b1);
        expect_grant("R5 single-point pool", 2'd2, 4'h1, 64'h0);
        xfer(1'b0, 4'd6, 32'h0100_0000, 1'b1);
        expect_grant("R6 second sp stream", 2'd3, 4'h2, 64'h0001_0000_0000_0000);
        xfer(1'b0, 4'd7, 32'h0002_0000, 1'b1);
        expect_err("R4 fifth task", 3'd3);
        xfer(1'b0, 4'd7, 32'h0002_0000, 1'b0);
        expect_err("R10 no-engine before mode", 3'd3);
        xfer(1'b1, 4'd4, 32'h0, 1'b0);
        chk(g_ok && g_eng == 2'd1, "R9 release mid engine", {61'd0, g_ok, g_eng}, {61'd0, 1'b1, 2'd1});
        xfer(1'b0, 4'd7, 32'h0602_0000, 1'b1);
        expect_grant("R7 R6 refill freed engine", 2'd1, 4'h4, 64'h0028_0008_0000_0000);
        xfer(1'b1, 4'd3, 32'h0, 1'b0);
        xfer(1'b0, 4'd8, 32'h38FC_0000, 1'b1);
        expect_err("R5 needs two streams", 3'd4);
        xfer(1'b0, 4'd8, 32'h18FC_0000, 1'b1);
        expect_grant("R6 scattered eight", 2'd0, 4'h8, 64'h03C0_FFF0_0000_0000);
        xfer(1'b1, 4'd5, 32'h0, 1'b0);
        xfer(1'b1, 4'd6, 32'h0, 1'b0);
        xfer(1'b1, 4'd7, 32'h0, 1'b0);
        xfer(1'b1, 4'd8, 32'h0, 1'b0);
        xfer(1'b0, 4'd9, 32'hFFFF_FFFF, 1'b0);
        expect_grant("R9 all freed full grant", 2'd0, 4'hF, 64'hFFFF_AAAA_5555_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank_modes();
        t_engines();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule